// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sits beside a small processor core and runs its two low-power modes. Software writes a request strobe for a deep "stop" mode or a lighter "suspend" mode. The sequencer holds the request until the core reports that the instruction doing the write has retired. It then drops the CPU clock enable, the high-frequency oscillator enable and the peripheral clock enable. In stop mode it can also drop the regulator enable.

The two modes leave in different ways. Stop is left only through a reset. If the regulator was switched off on entry, only the external reset pin can end it. Suspend ends on a port match, on a low-speed timer overflow, or on a comparator-low level when the comparator is enabled. After such a wake the oscillator comes back first. After a fixed settle delay the CPU clock returns together with a one-cycle resume pulse, and execution continues in place. A reset that ends either mode raises a one-cycle reset request carrying a cause code, so the core restarts from its reset vector.

Top module: `lpm_sequencer`

## Requirements
- R1: After the synchronous reset `rst`, cpu_clk_en, hfosc_en, periph_clk_en and reg_en are all 1, and resume_pulse, rst_req, rst_cause (2'b00) and wake_irq_pend are all 0.
- R2: A request strobe is only recorded. Mode entry happens on the first clock edge after the strobe's edge at which instr_done is 1. An instr_done in the same cycle as the strobe does not cause entry.
- R3: In stop mode, cpu_clk_en, hfosc_en and periph_clk_en are 0. reg_en stays 1 when reg_off_cfg was 0 at entry.
- R4: Port match, timer overflow and comparator-low events leave stop mode unchanged.
- R5: Any accepted reset makes rst_req 1 for exactly one cycle, with all enables back at 1. The cause is 2'b01 for pin, 2'b10 for missing-clock and 2'b11 for other internal resets. rst_cause is 2'b00 when rst_req is 0. mcd_rst is ignored while mcd_en is 0.
- R6: If reg_off_cfg is 1 on the entry edge of stop, reg_en is 0 throughout stop. In that state only pin_rst is accepted, and mcd_rst and int_rst are ignored.
- R7: In suspend, pm_wake, tmr_ovf or (cmp_low with cmp_en=1) sets hfosc_en on the next edge. cpu_clk_en and periph_clk_en return 16 cycles after hfosc_en, together with a resume_pulse that lasts one cycle. cmp_low with cmp_en=0 is ignored.
- R8: wake_irq_pend rises with resume_pulse when the waking source had its interrupt enabled: irq_en bit 0 for port match, bit 1 for the timer. It then holds until irq_ack. With the enable clear, or for a comparator wake, it stays 0.
- R9: A reset accepted during suspend or during the settle delay gives rst_req with its cause and produces no resume_pulse.
- R10: Stop and suspend strobes in the same cycle enter stop. Request strobes that arrive while in stop, suspend or settle are ignored.
- R11: Simultaneous resets are prioritised pin, then missing-clock, then internal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| stop_req | input | 1 | Stop request strobe from the control write |
| susp_req | input | 1 | Suspend request strobe from the control write |
| instr_done | input | 1 | Current instruction has retired |
| reg_off_cfg | input | 1 | Turn the regulator off during stop |
| pm_wake | input | 1 | Port match event |
| tmr_ovf | input | 1 | Low-speed timer overflow |
| cmp_low | input | 1 | Comparator output low |
| cmp_en | input | 1 | Comparator wake enable |
| irq_en | input | 2 | Interrupt enable: bit 0 port match, bit 1 timer |
| irq_ack | input | 1 | Clears the pending wake interrupt |
| pin_rst | input | 1 | External reset pin |
| mcd_rst | input | 1 | Missing-clock detector timeout |
| mcd_en | input | 1 | Missing-clock detector enabled |
| int_rst | input | 1 | Other internal reset |
| cpu_clk_en | output | 1 | CPU clock enable |
| hfosc_en | output | 1 | High-frequency oscillator enable |
| periph_clk_en | output | 1 | Digital peripheral clock enable |
| reg_en | output | 1 | Regulator enable |
| resume_pulse | output | 1 | One-cycle in-place resume |
| rst_req | output | 1 | One-cycle reset request |
| rst_cause | output | 2 | Reset cause code |
| wake_irq_pend | output | 1 | Wake interrupt awaiting service |

## Verification
Stop mode is driven with every wake source at once, with a masked missing-clock reset, and with the regulator turned off. This separates a sequencer that gates exit by mode from one that simply ORs all events. Suspend is woken by each of the three sources, with interrupt enables on and off. The comparison of the resulting flags shows that source attribution is correct, and cycle-exact sampling at the fifteenth and sixteenth settle cycles pins down the delay. Strobes that coincide with instr_done, simultaneous stop and suspend strobes, strobes during low power and stacked resets expose mistakes in entry timing and in priority.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    S_RUN    = 2'd0,
    S_STOP   = 2'd1,
    S_SUSP   = 2'd2,
    S_SETTLE = 2'd3
  } lpm_state_t;

  typedef enum logic [1:0] {
    RC_NONE = 2'b00,
    RC_PIN  = 2'b01,
    RC_MCD  = 2'b10,
    RC_INT  = 2'b11
  } rst_cause_t;

  localparam int IRQ_SRC_W = 2;
endpackage

// File: rtl/lpm_reset_arb.sv
module lpm_reset_arb
  import lpm_pkg::*;
(
  input  logic       pin_rst,
  input  logic       mcd_rst,
  input  logic       mcd_en,
  input  logic       int_rst,
  input  logic       pin_only,
  output logic       accept,
  output rst_cause_t cause
);
  logic mcd_ok, int_ok;

  assign mcd_ok = mcd_rst && mcd_en && !pin_only;
  assign int_ok = int_rst && !pin_only;

  always_comb begin
    cause = RC_NONE;
    if (pin_rst)     cause = RC_PIN;
    else if (mcd_ok) cause = RC_MCD;
    else if (int_ok) cause = RC_INT;
  end

  assign accept = (cause != RC_NONE);
endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int SETTLE_CYCLES = 16,
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic done
);
  logic [CNT_W-1:0] cnt;
  logic             run;

  assign done = run && (cnt == CNT_W'(SETTLE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (done) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    run |-> (int'(cnt) < SETTLE_CYCLES));
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !run |-> (cnt == '0));
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
  import lpm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 armed,
  input  logic                 pm_wake,
  input  logic                 tmr_ovf,
  input  logic                 cmp_low,
  input  logic                 cmp_en,
  input  logic [IRQ_SRC_W-1:0] irq_en,
  input  logic                 take_wake,
  input  logic                 resume_evt,
  input  logic                 flush,
  input  logic                 irq_ack,
  output logic                 wake,
  output logic                 irq_pend
);
  logic irq_src_q;

  assign wake = armed && (pm_wake || tmr_ovf || (cmp_low && cmp_en));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      irq_src_q <= 1'b0;
      irq_pend  <= 1'b0;
    end else begin
      if (take_wake)
        irq_src_q <= (pm_wake && irq_en[0]) || (tmr_ovf && irq_en[1]);
      else if (resume_evt)
        irq_src_q <= 1'b0;
      if (resume_evt && irq_src_q) irq_pend <= 1'b1;
      else if (irq_ack)            irq_pend <= 1'b0;
    end
  end

  p_irq_with_resume_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pend) |-> $past(resume_evt));
  p_irq_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_pend && irq_ack && !resume_evt && !flush) |=> !irq_pend);
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stop_req,
  input  logic                 susp_req,
  input  logic                 instr_done,
  input  logic                 reg_off_cfg,
  input  logic                 pm_wake,
  input  logic                 tmr_ovf,
  input  logic                 cmp_low,
  input  logic                 cmp_en,
  input  logic [IRQ_SRC_W-1:0] irq_en,
  input  logic                 irq_ack,
  input  logic                 pin_rst,
  input  logic                 mcd_rst,
  input  logic                 mcd_en,
  input  logic                 int_rst,
  output logic                 cpu_clk_en,
  output logic                 hfosc_en,
  output logic                 periph_clk_en,
  output logic                 reg_en,
  output logic                 resume_pulse,
  output logic                 rst_req,
  output logic [1:0]           rst_cause,
  output logic                 wake_irq_pend
);
  lpm_state_t st, nxt;
  rst_cause_t cause;
  logic accept, wake, settle_done;
  logic pend_stop, pend_susp, reg_off_q, reg_off_nxt;
  logic take_wake, resume_evt, pin_only;

  assign pin_only = (st == S_STOP) && reg_off_q;

  lpm_reset_arb u_arb (
    .pin_rst (pin_rst),
    .mcd_rst (mcd_rst),
    .mcd_en  (mcd_en),
    .int_rst (int_rst),
    .pin_only(pin_only),
    .accept  (accept),
    .cause   (cause)
  );

  lpm_wake_qual u_wake (
    .clk       (clk),
    .rst       (rst),
    .armed     (st == S_SUSP),
    .pm_wake   (pm_wake),
    .tmr_ovf   (tmr_ovf),
    .cmp_low   (cmp_low),
    .cmp_en    (cmp_en),
    .irq_en    (irq_en),
    .take_wake (take_wake),
    .resume_evt(resume_evt),
    .flush     (accept),
    .irq_ack   (irq_ack),
    .wake      (wake),
    .irq_pend  (wake_irq_pend)
  );

  lpm_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk  (clk),
    .rst  (rst),
    .start(take_wake),
    .abort(accept),
    .done (settle_done)
  );

  always_comb begin
    nxt = st;
    if (accept) begin
      nxt = S_RUN;
    end else begin
      unique case (st)
        S_RUN: begin
          if (pend_stop && instr_done)      nxt = S_STOP;
          else if (pend_susp && instr_done) nxt = S_SUSP;
        end
        S_SUSP:   if (wake) nxt = S_SETTLE;
        S_SETTLE: if (settle_done) nxt = S_RUN;
        default:  nxt = st;
      endcase
    end
  end

  assign take_wake   = !accept && (st == S_SUSP) && wake;
  assign resume_evt  = !accept && (st == S_SETTLE) && settle_done;
  assign reg_off_nxt = (st == S_STOP) ? reg_off_q : reg_off_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_RUN;
      pend_stop     <= 1'b0;
      pend_susp     <= 1'b0;
      reg_off_q     <= 1'b0;
      cpu_clk_en    <= 1'b1;
      hfosc_en      <= 1'b1;
      periph_clk_en <= 1'b1;
      reg_en        <= 1'b1;
      resume_pulse  <= 1'b0;
      rst_req       <= 1'b0;
      rst_cause     <= RC_NONE;
    end else begin
      st <= nxt;
      if (accept || st != S_RUN || nxt != S_RUN) begin
        pend_stop <= 1'b0;
        pend_susp <= 1'b0;
      end else begin
        pend_stop <= pend_stop | stop_req;
        pend_susp <= pend_susp | susp_req;
      end
      if (st == S_RUN && nxt == S_STOP) reg_off_q <= reg_off_cfg;
      else if (nxt != S_STOP)           reg_off_q <= 1'b0;
      cpu_clk_en    <= (nxt == S_RUN);
      periph_clk_en <= (nxt == S_RUN);
      hfosc_en      <= (nxt == S_RUN) || (nxt == S_SETTLE);
      reg_en        <= !((nxt == S_STOP) && reg_off_nxt);
      resume_pulse  <= resume_evt;
      rst_req       <= accept;
      rst_cause     <= accept ? cause : RC_NONE;
    end
  end

  p_osc_before_cpu_r7: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |-> ($past(hfosc_en) && !$past(cpu_clk_en)));
  p_resume_single_r7: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |=> !resume_pulse);
  p_cause_valid_r5: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (rst_cause != 2'b00 && cpu_clk_en && reg_en));
  p_req_single_r5: assert property (@(posedge clk) disable iff (rst)
    (rst_req && !pin_rst && !mcd_rst && !int_rst) |=> !rst_req);
  p_regoff_pin_only_r6: assert property (@(posedge clk) disable iff (rst)
    !reg_en |=> (!rst_req || rst_cause == 2'b01));
  p_stop_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_STOP) |=> (!hfosc_en || rst_req));
  p_gates_agree_r3: assert property (@(posedge clk) disable iff (rst)
    !hfosc_en |-> (!cpu_clk_en && !periph_clk_en));
endmodule

// File: tb/lpm_sequencer_test.sv
`timescale 1ns/1ps
module lpm_sequencer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 0, susp_req = 0, instr_done = 0, reg_off_cfg = 0;
  logic pm_wake = 0, tmr_ovf = 0, cmp_low = 0, cmp_en = 0;
  logic [1:0] irq_en = 2'b00;
  logic irq_ack = 0, pin_rst = 0, mcd_rst = 0, mcd_en = 0, int_rst = 0;
  logic cpu_clk_en, hfosc_en, periph_clk_en, reg_en, resume_pulse, rst_req, wake_irq_pend;
  logic [1:0] rst_cause;

  always #10 clk = ~clk;

  lpm_sequencer uut (
    .clk(clk), .rst(rst), .stop_req(stop_req), .susp_req(susp_req),
    .instr_done(instr_done), .reg_off_cfg(reg_off_cfg), .pm_wake(pm_wake),
    .tmr_ovf(tmr_ovf), .cmp_low(cmp_low), .cmp_en(cmp_en), .irq_en(irq_en),
    .irq_ack(irq_ack), .pin_rst(pin_rst), .mcd_rst(mcd_rst), .mcd_en(mcd_en),
    .int_rst(int_rst), .cpu_clk_en(cpu_clk_en), .hfosc_en(hfosc_en),
    .periph_clk_en(periph_clk_en), .reg_en(reg_en), .resume_pulse(resume_pulse),
    .rst_req(rst_req), .rst_cause(rst_cause), .wake_irq_pend(wake_irq_pend)
  );

  typedef struct {
    int         cyc;
    logic [8:0] v;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [8:0] mk(bit c, bit h, bit p, bit r, bit res,
                                    bit rr, logic [1:0] cs, bit irq);
    return {c, h, p, r, res, rr, cs, irq};
  endfunction

  localparam logic [8:0] RUNV  = 9'b1111_0_0_00_0;
  localparam logic [8:0] STOPV = 9'b0001_0_0_00_0;
  localparam logic [8:0] STOFF = 9'b0000_0_0_00_0;
  localparam logic [8:0] SUSPV = 9'b0001_0_0_00_0;
  localparam logic [8:0] SETV  = 9'b0101_0_0_00_0;

  task automatic expq(input int d, input logic [8:0] v, input string tag);
    item_t it;
    int pos;
    it.cyc = cyc + d; it.v = v; it.tag = tag;
    pos = q.size();
    while (pos > 0 && q[pos-1].cyc > it.cyc) pos--;
    q.insert(pos, it);
  endtask

  always @(negedge clk) begin
    logic [8:0] got;
    got = {cpu_clk_en, hfosc_en, periph_clk_en, reg_en, resume_pulse,
           rst_req, rst_cause, wake_irq_pend};
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.cyc < cyc || got !== it.v) begin
        fails++;
        $display("FAIL %s at cycle %0d: actual %b expected %b", it.tag, cyc, got, it.v);
      end
    end
  end

  task automatic enter(input bit stp, input logic [8:0] ev, input string tag);
    @(negedge clk); stop_req = stp; susp_req = !stp;
    @(negedge clk); stop_req = 0; susp_req = 0; instr_done = 1; expq(1, ev, tag);
    @(negedge clk); instr_done = 0;
  endtask

  task automatic wake_run(input int src, input logic [8:0] resv, input logic [8:0] after,
                          input string tag);
    @(negedge clk);
    if (src == 0) pm_wake = 1; else if (src == 1) tmr_ovf = 1; else cmp_low = 1;
    expq(1, SETV, {tag, " R7 osc on"});
    expq(16, SETV, {tag, " R7 still settling"});
    expq(17, resv, {tag, " R7 resume R8 flag"});
    expq(18, after, {tag, " R7 pulse ends"});
    @(negedge clk); pm_wake = 0; tmr_ovf = 0; cmp_low = 0;
    repeat (18) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; expq(1, RUNV, "R1 reset state");
    @(negedge clk);

    // R2: strobe coinciding with instr_done does not enter
    @(negedge clk); stop_req = 1; instr_done = 1; expq(1, RUNV, "R2 same-cycle done");
    @(negedge clk); stop_req = 0; instr_done = 0; expq(1, RUNV, "R2 waiting");
    @(negedge clk); instr_done = 1; expq(1, STOPV, "R3 stop gating");
    @(negedge clk); instr_done = 0;

    // R4 / R10: wake events and requests in stop are ignored
    @(negedge clk); pm_wake = 1; tmr_ovf = 1; cmp_low = 1; cmp_en = 1;
    susp_req = 1; instr_done = 1; expq(1, STOPV, "R4 wakes ignored");
    @(negedge clk); pm_wake = 0; tmr_ovf = 0; cmp_low = 0; susp_req = 0; instr_done = 0;
    repeat (20) @(negedge clk);
    expq(1, STOPV, "R4 R10 still stopped");

    // R5: masked then enabled missing-clock reset
    @(negedge clk); mcd_rst = 1; mcd_en = 0; expq(1, STOPV, "R5 mcd masked");
    @(negedge clk); mcd_rst = 0;
    @(negedge clk); mcd_rst = 1; mcd_en = 1; expq(1, mk(1,1,1,1,0,1,2'b10,0), "R5 mcd reset");
    @(negedge clk); mcd_rst = 0; expq(1, RUNV, "R5 single cycle");

    // R6: regulator off, only pin reset
    reg_off_cfg = 1;
    enter(1, STOFF, "R6 regulator off");
    reg_off_cfg = 0;
    @(negedge clk); int_rst = 1; mcd_rst = 1; expq(1, STOFF, "R6 internal ignored");
    @(negedge clk); int_rst = 0; mcd_rst = 0;
    @(negedge clk); pin_rst = 1; expq(1, mk(1,1,1,1,0,1,2'b01,0), "R6 pin reset");
    @(negedge clk); pin_rst = 0; expq(1, RUNV, "R6 back to run");

    // R7 / R8 / R10: port match with interrupt
    irq_en = 2'b01; cmp_en = 0;
    enter(0, SUSPV, "R2 suspend entry");
    @(negedge clk); cmp_low = 1; expq(1, SUSPV, "R7 comparator masked");
    @(negedge clk); cmp_low = 0; stop_req = 1; instr_done = 1; expq(1, SUSPV, "R10 request in suspend");
    @(negedge clk); stop_req = 0; instr_done = 0;
    wake_run(0, mk(1,1,1,1,1,0,2'b00,1), mk(1,1,1,1,0,0,2'b00,1), "pm");
    @(negedge clk); irq_ack = 1; expq(1, RUNV, "R8 ack clears");
    @(negedge clk); irq_ack = 0;

    // R8: timer wake with its interrupt disabled
    enter(0, SUSPV, "R2 suspend entry");
    wake_run(1, mk(1,1,1,1,1,0,2'b00,0), RUNV, "tmr");

    // R7 / R8: enabled comparator wake, never flags
    cmp_en = 1; irq_en = 2'b11;
    enter(0, SUSPV, "R2 suspend entry");
    wake_run(2, mk(1,1,1,1,1,0,2'b00,0), RUNV, "cmp");

    // R9: reset during settle gives no resume
    enter(0, SUSPV, "R2 suspend entry");
    @(negedge clk); pm_wake = 1; expq(1, SETV, "R9 settling");
    @(negedge clk); pm_wake = 0;
    repeat (5) @(negedge clk);
    @(negedge clk); int_rst = 1; expq(1, mk(1,1,1,1,0,1,2'b11,0), "R9 internal reset");
    @(negedge clk); int_rst = 0;
    for (int k = 1; k <= 20; k++) expq(k, RUNV, "R9 no resume");
    repeat (21) @(negedge clk);

    // R9: reset directly in suspend
    enter(0, SUSPV, "R2 suspend entry");
    @(negedge clk); pin_rst = 1; expq(1, mk(1,1,1,1,0,1,2'b01,0), "R9 pin in suspend");
    @(negedge clk); pin_rst = 0; expq(1, RUNV, "R9 run");

    // R10: simultaneous requests
    @(negedge clk); stop_req = 1; susp_req = 1;
    @(negedge clk); stop_req = 0; susp_req = 0; instr_done = 1; expq(1, STOPV, "R10 stop wins");
    @(negedge clk); instr_done = 0;
    @(negedge clk); pin_rst = 1; expq(1, mk(1,1,1,1,0,1,2'b01,0), "R5 pin exits stop");
    @(negedge clk); pin_rst = 0;

    // R11: priority of stacked resets in run
    @(negedge clk); pin_rst = 1; mcd_rst = 1; int_rst = 1; mcd_en = 1;
    expq(1, mk(1,1,1,1,0,1,2'b01,0), "R11 pin first");
    @(negedge clk); pin_rst = 0; expq(1, mk(1,1,1,1,0,1,2'b10,0), "R11 mcd over int");
    @(negedge clk); mcd_rst = 0; expq(1, mk(1,1,1,1,0,1,2'b11,0), "R11 int alone");
    @(negedge clk); int_rst = 0; expq(1, RUNV, "R5 cause clears");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      fails += q.size();
      $display("FAIL unmatched expectations: actual %0d left expected 0", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule